// File: doc/BRIEF.md
# DMA Channel Command Controller

This block holds the control state of one channel of a descriptor-driven copy, XOR and CRC engine. Software writes command bits that start, stop, pause or restart the channel. It also writes a configuration word, which holds an operation mode, two burst limits and an access-protection bit, and a next-descriptor pointer. The block keeps a three-valued channel state and sends a one-cycle start pulse to the datapath when a new operation begins. It returns to idle when the datapath signals done.

Each command is legal only in certain states. The alignment the descriptor pointer needs depends on the operation mode. An illegal command, a misaligned pointer, or a configuration or pointer write while the channel runs leaves all state unchanged and sets a sticky error flag. Software clears that flag through the command word.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset the state is idle (`state_o`=00), the mode is XOR (0), both burst limits are 4, protection is on, the pointer is 0, the error flag is clear and `start_o` is low.
- R2: The state encoding is 00 idle, 01 active and 10 paused. A command write (`wr_sel`=0, start on `wr_data[0]`) while idle, with an aligned pointer, makes the state active one cycle later. `start_o` is high for exactly that cycle.
- R3: Pause (`wr_data[2]`) is accepted only while active and moves the channel to paused. Restart (`wr_data[3]`) is accepted only while paused and moves the channel to active without a start pulse.
- R4: Stop (`wr_data[1]`) moves the channel from active to idle. Stop while idle changes nothing and raises no error. Stop while paused is illegal.
- R5: Start while paused resumes the channel to active without a start pulse. Start while active is illegal.
- R6: The modes are 0 XOR, 1 DMA copy, 2 CRC32 and 3 memory init. A start from idle needs pointer bits [5:0] clear in XOR mode and bits [4:0] clear in DMA and CRC32 modes. Memory-init mode has no alignment rule.
- R7: A configuration write (`wr_sel`=1) loads the source burst limit from bits [6:4], the destination burst limit from bits [10:8] and protection from bit 12. It loads the mode from bits [1:0] only when `mode_upd` is high.
- R8: A configuration or pointer write (`wr_sel`=2) while active is rejected: nothing changes and the error flag is set.
- R9: A rejected command leaves the state unchanged and sets a sticky error flag. A command with more than one of bits [3:0] set is also rejected. Bit 4 of a command write clears the flag, and a rejection in the same write wins.
- R10: `done_i` while active returns the channel to idle, and any write in that cycle is dropped. `done_i` in any other state has no effect.
- R11: Writes with `wr_sel`=3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target: 0 command, 1 configuration, 2 pointer |
| wr_data | input | W | Write data |
| mode_upd | input | 1 | Allow the mode field to be loaded on a configuration write |
| done_i | input | 1 | Operation finished, from the datapath |
| state_o | output | 2 | Channel state |
| start_o | output | 1 | One-cycle start pulse to the datapath |
| err_o | output | 1 | Sticky error flag |
| op_mode_o | output | 2 | Operation mode |
| src_burst_o | output | 3 | Source burst limit |
| dst_burst_o | output | 3 | Destination burst limit |
| prot_en_o | output | 1 | Access-protection enable |
| desc_ptr_o | output | W | Next-descriptor pointer |

## Verification
Every result is due one clock after the edge that takes the write or the done pulse. This covers the state, the start pulse, the error flag, the configuration fields and the pointer. The bench drives each stimulus on a falling edge and lets one rising edge pass. It advances its reference model at that edge and compares all outputs at the next falling edge. So every output is checked in the first cycle its new value is due, and the start pulse is checked to last that one cycle only.

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl #(
  parameter int W = 32,
  parameter int BW = 3,
  parameter int BURST_RST = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [W-1:0]  wr_data,
  input  logic          mode_upd,
  input  logic          done_i,
  output logic [1:0]    state_o,
  output logic          start_o,
  output logic          err_o,
  output logic [1:0]    op_mode_o,
  output logic [BW-1:0] src_burst_o,
  output logic [BW-1:0] dst_burst_o,
  output logic          prot_en_o,
  output logic [W-1:0]  desc_ptr_o
);
  localparam logic [1:0] S_IDLE = 2'b00, S_ACT = 2'b01, S_PAU = 2'b10;
  localparam logic [1:0] M_XOR = 2'd0, M_DMA = 2'd1, M_CRC = 2'd2;
  localparam int SRC_LSB = 4, DST_LSB = 8, PROT_BIT = 12;

  logic [1:0] st_d;
  logic       err_set, pulse_d;

  wire finish  = done_i && (state_o == S_ACT);
  wire cmd_wr  = wr_en && !finish && (wr_sel == 2'd0);
  wire cfg_wr  = wr_en && !finish && (wr_sel == 2'd1);
  wire ptr_wr  = wr_en && !finish && (wr_sel == 2'd2);
  wire busy    = (state_o == S_ACT);
  wire [3:0] cmd = wr_data[3:0];
  wire multi   = (cmd & (cmd - 4'd1)) != 4'd0;

  logic aligned;
  always_comb begin
    case (op_mode_o)
      M_XOR:        aligned = (desc_ptr_o[5:0] == 6'd0);
      M_DMA, M_CRC: aligned = (desc_ptr_o[4:0] == 5'd0);
      default:      aligned = 1'b1;
    endcase
  end

  always_comb begin
    st_d    = state_o;
    err_set = 1'b0;
    pulse_d = 1'b0;
    if (finish) begin
      st_d = S_IDLE;
    end else if (cmd_wr && cmd != 4'd0) begin
      if (multi) err_set = 1'b1;
      else if (cmd[0]) begin
        if (state_o == S_IDLE) begin
          if (aligned) begin
            st_d    = S_ACT;
            pulse_d = 1'b1;
          end else err_set = 1'b1;
        end else if (state_o == S_PAU) st_d = S_ACT;
        else err_set = 1'b1;
      end else if (cmd[1]) begin
        if (state_o == S_ACT) st_d = S_IDLE;
        else if (state_o != S_IDLE) err_set = 1'b1;
      end else if (cmd[2]) begin
        if (state_o == S_ACT) st_d = S_PAU;
        else err_set = 1'b1;
      end else begin
        if (state_o == S_PAU) st_d = S_ACT;
        else err_set = 1'b1;
      end
    end else if ((cfg_wr || ptr_wr) && busy) begin
      err_set = 1'b1;
    end
  end

  wire err_clr = cmd_wr && wr_data[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_o <= S_IDLE;
      start_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      state_o <= st_d;
      start_o <= pulse_d;
      err_o   <= err_set | (err_o & ~err_clr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_mode_o   <= M_XOR;
      src_burst_o <= BW'(BURST_RST);
      dst_burst_o <= BW'(BURST_RST);
      prot_en_o   <= 1'b1;
      desc_ptr_o  <= '0;
    end else begin
      if (cfg_wr && !busy) begin
        src_burst_o <= wr_data[SRC_LSB +: BW];
        dst_burst_o <= wr_data[DST_LSB +: BW];
        prot_en_o   <= wr_data[PROT_BIT];
        if (mode_upd) op_mode_o <= wr_data[1:0];
      end
      if (ptr_wr && !busy) desc_ptr_o <= wr_data;
    end
  end
endmodule

// File: rtl/dma_chan_ctl_chk.sv
module dma_chan_ctl_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [1:0]   wr_sel,
  input logic [W-1:0] wr_data,
  input logic         mode_upd,
  input logic         done_i,
  input logic [1:0]   state_o,
  input logic         start_o,
  input logic         err_o,
  input logic [1:0]   op_mode_o,
  input logic [W-1:0] desc_ptr_o
);
  a_r2_pulse_active: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (state_o == 2'b01 && $past(state_o) == 2'b00));

  a_r2_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'b11);

  a_r3_pause_from_active: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b10 && $past(state_o) != 2'b10) |-> $past(state_o) == 2'b01);

  a_r7_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(op_mode_o) |-> $past(wr_en && wr_sel == 2'd1 && mode_upd));

  a_r8_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 2'b01 |=> $stable(desc_ptr_o));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_o) |-> $past(wr_en && wr_sel == 2'd0 && wr_data[4]));

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && state_o == 2'b01) |=> (state_o == 2'b00 && !start_o));
endmodule

bind dma_chan_ctl dma_chan_ctl_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .mode_upd(mode_upd), .done_i(done_i), .state_o(state_o), .start_o(start_o),
  .err_o(err_o), .op_mode_o(op_mode_o), .desc_ptr_o(desc_ptr_o)
);

// File: tb/dma_chan_ctl_tb_top.sv
module dma_chan_ctl_tb_top;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, mode_upd = 0, done_i = 0;
  logic [1:0] wr_sel = 0;
  logic [31:0] wr_data = 0;
  logic [1:0] state_o, op_mode_o;
  logic start_o, err_o, prot_en_o;
  logic [2:0] src_burst_o, dst_burst_o;
  logic [31:0] desc_ptr_o;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [1:0] m_st, m_mode;
  logic m_err, m_pulse, m_prot;
  logic [2:0] m_src, m_dst;
  logic [31:0] m_ptr;

  always #5 clk = ~clk;

  dma_chan_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .mode_upd(mode_upd), .done_i(done_i), .state_o(state_o), .start_o(start_o),
    .err_o(err_o), .op_mode_o(op_mode_o), .src_burst_o(src_burst_o),
    .dst_burst_o(dst_burst_o), .prot_en_o(prot_en_o), .desc_ptr_o(desc_ptr_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit ptr_ok(input logic [1:0] md, input logic [31:0] p);
    if (md == 2'd0) return p[5:0] == 0;
    if (md == 2'd3) return 1'b1;
    return p[4:0] == 0;
  endfunction

  task automatic model(input bit we, input logic [1:0] sel, input logic [31:0] d,
                       input bit upd, input bit dn);
    m_pulse = 0;
    if (dn && m_st == 2'b01) begin
      m_st = 2'b00;
      return;
    end
    if (!we) return;
    if (sel == 2'd0) begin
      logic set;
      set = 0;
      if (d[4]) m_err = 0;
      if ($countones(d[3:0]) > 1) set = 1;
      else if (d[0]) begin
        if (m_st == 2'b00) begin
          if (ptr_ok(m_mode, m_ptr)) begin m_st = 2'b01; m_pulse = 1; end
          else set = 1;
        end else if (m_st == 2'b10) m_st = 2'b01;
        else set = 1;
      end else if (d[1]) begin
        if (m_st == 2'b01) m_st = 2'b00;
        else if (m_st == 2'b10) set = 1;
      end else if (d[2]) begin
        if (m_st == 2'b01) m_st = 2'b10; else set = 1;
      end else if (d[3]) begin
        if (m_st == 2'b10) m_st = 2'b01; else set = 1;
      end
      if (set) m_err = 1;
    end else if (sel == 2'd1) begin
      if (m_st == 2'b01) m_err = 1;
      else begin
        m_src = d[6:4]; m_dst = d[10:8]; m_prot = d[12];
        if (upd) m_mode = d[1:0];
      end
    end else if (sel == 2'd2) begin
      if (m_st == 2'b01) m_err = 1; else m_ptr = d;
    end
  endtask

  task automatic compare_all();
    check("R2 state", {30'd0, state_o}, {30'd0, m_st});
    check("R2 start pulse", {31'd0, start_o}, {31'd0, m_pulse});
    check("R9 error flag", {31'd0, err_o}, {31'd0, m_err});
    check("R7 mode", {30'd0, op_mode_o}, {30'd0, m_mode});
    check("R7 config fields", {25'd0, m_prot == prot_en_o, src_burst_o, dst_burst_o},
          {25'd0, 1'b1, m_src, m_dst});
    check("R8 pointer", desc_ptr_o, m_ptr);
  endtask

  task automatic step(input bit we, input logic [1:0] sel, input logic [31:0] d,
                      input bit upd, input bit dn);
    wr_en = we; wr_sel = sel; wr_data = d; mode_upd = upd; done_i = dn;
    @(posedge clk);
    model(we, sel, d, upd, dn);
    @(negedge clk);
    wr_en = 0; done_i = 0; mode_upd = 0;
    compare_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_st = 0; m_mode = 0; m_err = 0; m_pulse = 0; m_prot = 1;
    m_src = 4; m_dst = 4; m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset state", {30'd0, state_o}, 32'd0);
    check("R1 reset bursts", {26'd0, src_burst_o, dst_burst_o}, {26'd0, 3'd4, 3'd4});
    check("R1 reset protect", {31'd0, prot_en_o}, 32'd1);
    check("R1 reset error/pulse/ptr", {err_o, start_o, desc_ptr_o[29:0]}, 32'd0);

    // R6: 0x20 misaligned for XOR, fine for DMA
    step(1, 2'd2, 32'h20, 0, 0);
    step(1, 2'd0, 32'h1, 0, 0);
    check("R6 xor misaligned stays idle", {30'd0, state_o}, 32'd0);
    step(1, 2'd0, 32'h10, 0, 0);
    check("R9 clear", {31'd0, err_o}, 32'd0);
    step(1, 2'd1, 32'h1, 1, 0);
    step(1, 2'd0, 32'h1, 0, 0);
    check("R2 active with pulse", {30'd0, state_o, start_o}, {29'd0, 3'b011});
    step(0, 2'd0, 0, 0, 0);
    check("R2 pulse one cycle", {31'd0, start_o}, 32'd0);
    step(1, 2'd2, 32'h40, 0, 0);
    check("R8 ptr write while active", desc_ptr_o, 32'h20);
    step(1, 2'd0, 32'h14, 0, 0);
    check("R3 pause", {30'd0, state_o}, 32'd2);
    step(1, 2'd0, 32'h2, 0, 0);
    check("R4 stop while paused error", {31'd0, err_o}, 32'd1);
    step(1, 2'd0, 32'h11, 0, 0);
    check("R5 start from paused no pulse", {30'd0, state_o, start_o}, {29'd0, 3'b010});
    step(1, 2'd0, 32'h4, 0, 1);
    check("R10 done wins over write", {30'd0, state_o}, 32'd0);
    step(1, 2'd0, 32'h2, 0, 0);
    check("R4 stop idle no error", {31'd0, err_o}, 32'd0);
    step(1, 2'd3, 32'hFFFF_FFFF, 1, 0);
    check("R11 sel3 ignored", {30'd0, op_mode_o}, 32'd1);
    step(1, 2'd0, 32'h3, 0, 0);
    check("R9 multi-bit rejected", {31'd0, err_o}, 32'd1);
    step(1, 2'd0, 32'h10, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      int k;
      logic [31:0] d;
      k = $urandom_range(0, 9);
      d = $urandom;
      if (k < 5) begin
        logic [31:0] c;
        c = 32'h1 << $urandom_range(0, 3);
        if ($urandom_range(0, 9) == 0) c = d[4:0];
        else if ($urandom_range(0, 4) == 0) c = c | 32'h10;
        step(1, 2'd0, c, 0, 0);
      end else if (k == 5) step(1, 2'd1, d, $urandom_range(0, 1), 0);
      else if (k == 6) step(1, 2'd2, d & ~(32'h3F >> $urandom_range(0, 1)) | ($urandom_range(0, 3) == 0 ? d[5:0] : 0), 0, 0);
      else if (k == 7) step(1, 2'(d[1:0]), d, 1, 1);
      else if (k == 8) step(0, 2'd0, 0, 0, 1);
      else step(1, 2'd3, d, 1, 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule